// File: doc/BRIEF.md
# Cache Tag Store with Built-in Hit Compare

This block is the tag side of a direct-mapped cache. Each index holds a tag word, a valid flag and a dirty flag. The incoming tag is compared with the addressed entry in the same cycle. A hit indication and the stored dirty flag come straight back to the cache controller, so the controller can decide on a hit or a write-back without a separate read cycle.

Writes are synchronous and happen on the rising clock edge. Reads and compares are combinational from the index and the tag inputs. The bidirectional tag bus is split into an input, an output and a drive-enable flag. A diagnostic readout drives the stored tag onto the output. An active-low clear input invalidates the whole store in one clock.

A small sequencer tracks clearing. Its states are:
- `ST_RUN`: normal operation.
- `ST_CLEAR`: the clear input is low.
- `ST_RECOVER`: a counted lock-out after the clear input returns high.

Its transitions are:
- `ST_RUN` to `ST_CLEAR` when the clear input is sampled low.
- `ST_CLEAR` to `ST_RECOVER` when the clear input is sampled high. If the recovery count is zero, this transition goes to `ST_RUN` instead.
- `ST_RECOVER` to `ST_RUN` when the counter reaches zero.
- `ST_RECOVER` to `ST_CLEAR` when the clear input is sampled low again.

Writes are accepted only in `ST_RUN`.

Top module: `tag_match_store`

## Requirements
- R1: At a rising edge where `wr_n`=0, `oe_n`=1 and `clr_n`=1, with the sequencer in `ST_RUN`, the entry at `idx` takes `tag_in`, `valid_in` and `dirty_in`.
- R2: A write attempted with `oe_n`=0 is ignored, and the addressed entry keeps its tag, valid and dirty values.
- R3: With `oe_n`=0, `wr_n`=1 and `clr_n`=1, `tag_drive`=1 and `tag_out` shows the stored tag of `idx` in the same cycle. In every other input combination, `tag_drive`=0.
- R4: While `wr_n`=0, `oe_n`=1 and `clr_n`=1, `tag_out` equals `tag_in` and `dirty_out` equals `dirty_in` (write pass-through).
- R5: With `wr_n`=1, `oe_n`=1 and `clr_n`=1, `match`=1 exactly when the stored valid flag of `idx` is 1 and the stored tag equals `tag_in`.
- R6: `match` is 0 whenever `wr_n`=0 or `oe_n`=0.
- R7: Outside a write pass-through and with `clr_n`=1, `dirty_out` shows the stored dirty flag of `idx`.
- R8: While `clr_n`=0, `match`, `dirty_out` and `tag_drive` are all 0. Every rising edge with `clr_n`=0 clears all valid and dirty flags. The stored tags are kept.
- R9: After a clear, writes are ignored at the first rising edge that samples `clr_n`=1 and at the next `REC_CYC` edges. The edge after those accepts writes.
- R10: `rst_n`=0 asynchronously clears all valid and dirty flags and returns the sequencer to `ST_RUN`. The first edge after reset release accepts writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes and clears act on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| idx | input | IDX_W | Entry index |
| tag_in | input | TAG_W | Tag to compare or write |
| valid_in | input | 1 | Valid flag to write |
| dirty_in | input | 1 | Dirty flag to write |
| wr_n | input | 1 | Active-low write enable |
| oe_n | input | 1 | Active-low tag readout enable |
| clr_n | input | 1 | Active-low flash invalidate |
| match | output | 1 | Hit indication |
| dirty_out | output | 1 | Dirty flag of the addressed entry |
| tag_out | output | TAG_W | Tag bus output value |
| tag_drive | output | 1 | Tag bus drive enable |

## Verification
The bench goes after four corner cases:
- An entry that holds the right tag but has its valid flag cleared. A comparator that ignores the flag reports a false hit there.
- A write attempted during readout. A design that does not gate that write corrupts the entry, and a later compare exposes it.
- The recovery window, probed at the last blocked edge and at the first accepted edge. An off-by-one counter either accepts a write one edge early or drops the first legal write.
- A clear followed by a compare and a readout. A store that forgets to flush the flags keeps hitting, and one that wipes the tags as well returns zero on readout.

// File: rtl/tagm_pkg.sv
package tagm_pkg;

    typedef enum logic [1:0] {
        ST_RUN     = 2'd0,
        ST_CLEAR   = 2'd1,
        ST_RECOVER = 2'd2
    } tagm_state_e;

endpackage

// File: rtl/tagm_seq.sv
module tagm_seq
    import tagm_pkg::*;
#(
    parameter int REC_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_n,
    output logic wr_ok
);
    localparam int CNT_W = (REC_CYC > 1) ? $clog2(REC_CYC) : 1;

    tagm_state_e      st_q, st_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_RUN;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    // transitions
    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        unique case (st_q)
            ST_RUN: begin
                if (!clr_n) st_d = ST_CLEAR;
            end
            ST_CLEAR: begin
                if (clr_n) begin
                    if (REC_CYC == 0) begin
                        st_d = ST_RUN;
                    end else begin
                        st_d  = ST_RECOVER;
                        cnt_d = CNT_W'(REC_CYC - 1);
                    end
                end
            end
            ST_RECOVER: begin
                if (!clr_n)             st_d  = ST_CLEAR;
                else if (cnt_q == '0)   st_d  = ST_RUN;
                else                    cnt_d = cnt_q - CNT_W'(1);
            end
            default: st_d = ST_RUN;
        endcase
    end

    // outputs
    always_comb begin
        wr_ok = (st_q == ST_RUN);
    end

endmodule

// File: rtl/tagm_status.sv
module tagm_status #(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic          v_in,
    input  logic          d_in,
    output logic          v_out,
    output logic          d_out
);
    localparam int DEPTH = 1 << AW;

    logic vbit [DEPTH];
    logic dbit [DEPTH];

    for (genvar e = 0; e < DEPTH; e++) begin : g_ent
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                vbit[e] <= 1'b0;
                dbit[e] <= 1'b0;
            end else if (flush) begin
                vbit[e] <= 1'b0;
                dbit[e] <= 1'b0;
            end else if (we && (addr == AW'(e))) begin
                vbit[e] <= v_in;
                dbit[e] <= d_in;
            end
        end
    end

    assign v_out = vbit[addr];
    assign d_out = dbit[addr];

endmodule

// File: rtl/tagm_tag_array.sv
module tagm_tag_array #(
    parameter int AW = 8,
    parameter int DW = 14
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[addr] <= wdata;
    end

    assign rdata = mem[addr];

endmodule

// File: rtl/tagm_cmp.sv
module tagm_cmp #(
    parameter int DW = 14
) (
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    output logic          eq
);
    logic [DW-1:0] diff;

    for (genvar i = 0; i < DW; i++) begin : g_bit
        assign diff[i] = a[i] ^ b[i];
    end

    assign eq = ~|diff;

endmodule

// File: rtl/tag_match_store.sv
module tag_match_store #(
    parameter int IDX_W   = 8,
    parameter int TAG_W   = 14,
    parameter int REC_CYC = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] idx,
    input  logic [TAG_W-1:0] tag_in,
    input  logic             valid_in,
    input  logic             dirty_in,
    input  logic             wr_n,
    input  logic             oe_n,
    input  logic             clr_n,
    output logic             match,
    output logic             dirty_out,
    output logic [TAG_W-1:0] tag_out,
    output logic             tag_drive
);
    logic             wr_ok;
    logic             wr_cyc;
    logic             rd_cyc;
    logic             cmp_cyc;
    logic             we;
    logic             v_rd;
    logic             d_rd;
    logic             tag_eq;
    logic [TAG_W-1:0] tag_rd;

    assign wr_cyc  = clr_n && !wr_n && oe_n;
    assign rd_cyc  = clr_n && wr_n && !oe_n;
    assign cmp_cyc = clr_n && wr_n && oe_n;
    assign we      = wr_cyc && wr_ok;

    tagm_seq #(.REC_CYC(REC_CYC)) u_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_n (clr_n),
        .wr_ok (wr_ok)
    );

    tagm_status #(.AW(IDX_W)) u_status (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (!clr_n),
        .we    (we),
        .addr  (idx),
        .v_in  (valid_in),
        .d_in  (dirty_in),
        .v_out (v_rd),
        .d_out (d_rd)
    );

    tagm_tag_array #(.AW(IDX_W), .DW(TAG_W)) u_tags (
        .clk   (clk),
        .we    (we),
        .addr  (idx),
        .wdata (tag_in),
        .rdata (tag_rd)
    );

    tagm_cmp #(.DW(TAG_W)) u_cmp (
        .a  (tag_rd),
        .b  (tag_in),
        .eq (tag_eq)
    );

    always_comb begin
        match     = cmp_cyc && v_rd && tag_eq;
        tag_drive = rd_cyc;
        if (wr_cyc) begin
            tag_out   = tag_in;
            dirty_out = dirty_in;
        end else begin
            tag_out   = rd_cyc ? tag_rd : '0;
            dirty_out = clr_n && d_rd;
        end
    end

endmodule

// File: rtl/tagm_checker.sv
module tagm_checker #(
    parameter int TAG_W = 14
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_n,
    input logic             oe_n,
    input logic             clr_n,
    input logic             dirty_in,
    input logic [TAG_W-1:0] tag_in,
    input logic             match,
    input logic             dirty_out,
    input logic [TAG_W-1:0] tag_out,
    input logic             tag_drive
);
    p_wr_blocks_match_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_n |-> !match);

    p_oe_blocks_match_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !oe_n |-> !match);

    p_clear_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_n |-> (!match && !dirty_out && !tag_drive));

    p_clear_flush_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_n |=> !match);

    p_read_drives_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!oe_n && wr_n && clr_n) |-> tag_drive);

    p_drive_only_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tag_drive |-> (!oe_n && wr_n && clr_n));

    p_passthru_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_n && oe_n && clr_n) |-> (dirty_out == dirty_in && tag_out == tag_in));
endmodule

bind tag_match_store tagm_checker #(.TAG_W(TAG_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_n      (wr_n),
    .oe_n      (oe_n),
    .clr_n     (clr_n),
    .dirty_in  (dirty_in),
    .tag_in    (tag_in),
    .match     (match),
    .dirty_out (dirty_out),
    .tag_out   (tag_out),
    .tag_drive (tag_drive)
);

// File: tb/test_tag_match_store.sv
module test_tag_match_store;
    localparam int IDX_W = 8;
    localparam int TAG_W = 14;
    localparam int REC   = 3;
    localparam int NV    = 16;
    // vector: [27:26] op, [25:18] idx, [17:4] tag, [3] v, [2] d, [1] exp match, [0] exp dirty
    // op 0 = write, 1 = compare, 2 = readout, 3 = write with readout enabled (illegal)
    localparam logic [27:0] VEC [NV] = '{
        {2'd0, 8'h05, 14'h1234, 1'b1, 1'b0, 1'b0, 1'b0},
        {2'd0, 8'h06, 14'h2ABC, 1'b1, 1'b1, 1'b0, 1'b1},
        {2'd0, 8'h07, 14'h0F0F, 1'b0, 1'b1, 1'b0, 1'b1},
        {2'd1, 8'h05, 14'h1234, 1'b0, 1'b0, 1'b1, 1'b0},
        {2'd1, 8'h05, 14'h1235, 1'b0, 1'b0, 1'b0, 1'b0},
        {2'd1, 8'h06, 14'h2ABC, 1'b0, 1'b0, 1'b1, 1'b1},
        {2'd1, 8'h07, 14'h0F0F, 1'b0, 1'b0, 1'b0, 1'b1},
        {2'd2, 8'h06, 14'h2ABC, 1'b0, 1'b0, 1'b0, 1'b1},
        {2'd3, 8'h05, 14'h3FFF, 1'b1, 1'b1, 1'b0, 1'b0},
        {2'd1, 8'h05, 14'h1234, 1'b0, 1'b0, 1'b1, 1'b0},
        {2'd1, 8'h05, 14'h3FFF, 1'b0, 1'b0, 1'b0, 1'b0},
        {2'd0, 8'h05, 14'h0000, 1'b1, 1'b1, 1'b0, 1'b1},
        {2'd1, 8'h05, 14'h0000, 1'b0, 1'b0, 1'b1, 1'b1},
        {2'd1, 8'hFF, 14'h0000, 1'b0, 1'b0, 1'b0, 1'b0},
        {2'd0, 8'hFF, 14'h3FFF, 1'b1, 1'b0, 1'b0, 1'b0},
        {2'd1, 8'hFF, 14'h3FFF, 1'b0, 1'b0, 1'b1, 1'b0}
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [IDX_W-1:0] idx = '0;
    logic [TAG_W-1:0] tag_in = '0;
    logic             valid_in = 1'b0;
    logic             dirty_in = 1'b0;
    logic             wr_n = 1'b1;
    logic             oe_n = 1'b1;
    logic             clr_n = 1'b1;
    logic             match;
    logic             dirty_out;
    logic [TAG_W-1:0] tag_out;
    logic             tag_drive;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    tag_match_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .REC_CYC(REC)) i_tag_match_store (
        .clk, .rst_n, .idx, .tag_in, .valid_in, .dirty_in, .wr_n, .oe_n, .clr_n,
        .match, .dirty_out, .tag_out, .tag_drive
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic drive(input logic w, input logic o, input logic [IDX_W-1:0] i,
                         input logic [TAG_W-1:0] t, input logic v, input logic d);
        @(negedge clk);
        wr_n = w; oe_n = o; idx = i; tag_in = t; valid_in = v; dirty_in = d;
        #1;
    endtask

    initial begin
        #(200000 * 5);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        chk("R10 reset match", match, 0);
        chk("R10 reset dirty", dirty_out, 0);
        chk("R10 reset drive", tag_drive, 0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int n = 0; n < NV; n++) begin
            logic [1:0]       op;
            logic [TAG_W-1:0] t;
            op = VEC[n][27:26];
            t  = VEC[n][17:4];
            unique case (op)
                2'd0: begin
                    drive(1'b0, 1'b1, VEC[n][25:18], t, VEC[n][3], VEC[n][2]);
                    chk("R1 R4 pass dirty", dirty_out, VEC[n][0]);
                    chk("R4 pass tag", tag_out, t);
                    chk("R6 write match", match, 0);
                end
                2'd1: begin
                    drive(1'b1, 1'b1, VEC[n][25:18], t, 1'b0, 1'b0);
                    chk("R1 R5 match", match, VEC[n][1]);
                    chk("R7 dirty", dirty_out, VEC[n][0]);
                    chk("R3 no drive", tag_drive, 0);
                end
                2'd2: begin
                    drive(1'b1, 1'b0, VEC[n][25:18], '0, 1'b0, 1'b0);
                    chk("R3 drive", tag_drive, 1);
                    chk("R3 readout", tag_out, t);
                    chk("R6 read match", match, 0);
                    chk("R7 read dirty", dirty_out, VEC[n][0]);
                end
                default: begin
                    drive(1'b0, 1'b0, VEC[n][25:18], t, VEC[n][3], VEC[n][2]);
                    chk("R2 R6 illegal match", match, 0);
                    chk("R3 illegal drive", tag_drive, 0);
                end
            endcase
        end

        // clear: idx 05 holds tag 0000, valid, dirty
        drive(1'b1, 1'b1, 8'h05, 14'h0000, 1'b0, 1'b0);
        chk("R8 pre-clear hit", match, 1);
        clr_n = 1'b0;
        #1;
        chk("R8 clear match", match, 0);
        chk("R8 clear dirty", dirty_out, 0);
        drive(1'b1, 1'b0, 8'h05, 14'h0000, 1'b0, 1'b0);
        chk("R8 clear drive", tag_drive, 0);
        // one edge with clear low has passed
        drive(1'b1, 1'b1, 8'h05, 14'h0000, 1'b0, 1'b0);
        clr_n = 1'b1;
        #1;
        chk("R8 flushed match", match, 0);
        chk("R8 flushed dirty", dirty_out, 0);
        // edges 1..REC after the first high-sampling edge stay blocked
        for (int k = 1; k <= REC; k++) begin
            drive(1'b0, 1'b1, IDX_W'(8'h20 + k), TAG_W'(k), 1'b1, 1'b0);
        end
        drive(1'b0, 1'b1, 8'h30, 14'h0155, 1'b1, 1'b1);
        drive(1'b1, 1'b1, IDX_W'(8'h20 + REC), TAG_W'(REC), 1'b0, 1'b0);
        chk("R9 last blocked", match, 0);
        drive(1'b1, 1'b1, 8'h21, 14'h0001, 1'b0, 1'b0);
        chk("R9 first blocked", match, 0);
        drive(1'b1, 1'b1, 8'h30, 14'h0155, 1'b0, 1'b0);
        chk("R9 first accepted", match, 1);
        chk("R9 accepted dirty", dirty_out, 1);
        drive(1'b1, 1'b0, 8'h06, 14'h0000, 1'b0, 1'b0);
        chk("R8 tag kept", tag_out, 14'h2ABC);

        // reset mid-run
        drive(1'b1, 1'b1, 8'h30, 14'h0155, 1'b0, 1'b0);
        rst_n = 1'b0;
        #1;
        chk("R10 reset flush match", match, 0);
        chk("R10 reset flush dirty", dirty_out, 0);
        @(negedge clk);
        rst_n = 1'b1;
        drive(1'b0, 1'b1, 8'h40, 14'h0007, 1'b1, 1'b1);
        drive(1'b1, 1'b1, 8'h40, 14'h0007, 1'b0, 1'b0);
        chk("R10 write after reset", match, 1);
        chk("R10 dirty after reset", dirty_out, 1);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule